// File: doc/BRIEF.md
# Storage Cycle Sequencer with I/O Entry

This block sequences one word-wide storage cycle through eight timing phases, T0 to T7, advancing one phase per clock once a cycle is started. The first half of the cycle (T0 to T3) reads a word into the storage buffer register (SBR). The second half (T4 to T7) writes the SBR back to a small behavioural memory. If nothing replaces the SBR in between, the word read is regenerated unchanged.

Two I/O command types let an external bus reach the SBR. A sense-style command inhibits storage use for the whole cycle, so the memory is not accessed, and the bus value is captured at T1 in place of a memory read. A read-style command reads normally and then captures the bus at T5, so the bus value becomes the new stored word. All bus captures use one SBR load strobe, taken from the falling edge of an active-low entry-sample signal. Each byte carries an odd-parity bit, and the word is checked at T6. Storage use is turned off whenever the sequencer is idle and the machine is stopped.

Top module: `stg_cycle_seq`

## Requirements
- R1: A cycle starts only when start_i is high, run_i is high and no cycle is in progress. In the following clocks phase_o shows 0 through 7, one value per clock, and then returns to 0. cycle_done_o is high only during phase 7.
- R2: Command codes on cmd_i, sampled with start_i: 0 is a memory cycle, 1 is sense, 2 is read, and 3 is reserved and behaves exactly like a memory cycle.
- R3: The SBR load strobe fires only on a high-to-low transition of the active-low entry-sample signal. Entry-sample is low in T1 of a cycle that is not using storage, or in T5 of a read cycle. The strobe therefore fires at most once per entry, never in two consecutive clocks, and only in T1 or T5.
- R4: A memory cycle loads the addressed word into the SBR at T1 and writes it back unchanged at T7.
- R5: A sense cycle drives nsu_o high for the whole cycle and leaves memory untouched. The SBR takes io_bus_i as sampled in T1. Bus changes after T1 have no effect.
- R6: A read cycle stores io_bus_i as sampled in T5 into the SBR and then into memory at T7. Bus values before T5 and after T5 have no effect.
- R7: A bus load generates one parity bit per 8-bit byte, so that each byte plus its bit has odd weight. After reset every memory word, including its parity bits, is all zeros and therefore has even parity.
- R8: At T6 the SBR is checked. If any byte plus its parity bit has even weight, parity_error_o is set. The flag stays set until rst_ni is asserted.
- R9: While idle, nsu_o is high when run_i is low and low when run_i is high. While run_i is low, start_i is ignored.
- R10: mem_data_o shows the SBR data word. After reset it is 0 and phase_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one timing phase per cycle |
| rst_ni | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Machine running; low means stopped |
| start_i | input | 1 | Request a storage cycle |
| cmd_i | input | 2 | Command code (0 memory, 1 sense, 2 read, 3 as memory) |
| addr_i | input | 4 | Word address, sampled at start |
| io_bus_i | input | 16 | I/O bus data |
| mem_data_o | output | 16 | SBR data word |
| phase_o | output | 3 | Current timing phase |
| cycle_done_o | output | 1 | High during T7 |
| nsu_o | output | 1 | Storage use not active |
| parity_error_o | output | 1 | Sticky parity-check flag |

## Verification
Every address is written by a read cycle whose bus holds a decoy value until T3 and a different value after T6. The stored result therefore shows which of the three bus windows was sampled. Memory cycles are then run over all addresses, twice, to show that regeneration does not alter words. Sense cycles present one value in T1 and a different one later; a memory cycle afterwards shows the word stored in memory is unaffected. After a fresh reset, a memory cycle on an unwritten word raises the parity flag, and later good cycles leave it set until reset. A read cycle on an unwritten word shows the T5 load masks the bad word before the T6 check.

// File: rtl/stg_pkg.sv
package stg_pkg;
  localparam int DATA_W  = 16;
  localparam int BYTE_W  = 8;
  localparam int N_BYTES = DATA_W / BYTE_W;
  localparam int PHASES  = 8;
  localparam int PHASE_W = $clog2(PHASES);
  localparam int ADDR_W  = 4;
  localparam int DEPTH   = 1 << ADDR_W;
  localparam int WORD_W  = DATA_W + N_BYTES;

  localparam logic [PHASE_W-1:0] PH_FETCH = PHASE_W'(1);
  localparam logic [PHASE_W-1:0] PH_ENTRY = PHASE_W'(5);
  localparam logic [PHASE_W-1:0] PH_CHECK = PHASE_W'(6);
  localparam logic [PHASE_W-1:0] PH_LAST  = PHASE_W'(PHASES - 1);

  typedef enum logic [1:0] {
    CMD_MEM   = 2'd0,
    CMD_SENSE = 2'd1,
    CMD_READ  = 2'd2,
    CMD_RSVD  = 2'd3
  } cmd_e;

  typedef struct packed {
    logic [N_BYTES-1:0] par;
    logic [DATA_W-1:0]  data;
  } word_t;

  function automatic logic [N_BYTES-1:0] gen_par(input logic [DATA_W-1:0] d);
    logic [N_BYTES-1:0] p;
    for (int b = 0; b < N_BYTES; b++) p[b] = ~^d[b*BYTE_W +: BYTE_W];
    return p;
  endfunction

  function automatic logic par_bad(input word_t w);
    logic bad;
    bad = 1'b0;
    for (int b = 0; b < N_BYTES; b++)
      if (^{w.par[b], w.data[b*BYTE_W +: BYTE_W]} == 1'b0) bad = 1'b1;
    return bad;
  endfunction
endpackage

// File: rtl/stg_phase_ctr.sv
module stg_phase_ctr
  import stg_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic               start_i,
  input  logic [1:0]         cmd_i,
  input  logic [ADDR_W-1:0]  addr_i,
  output logic               busy_o,
  output logic [PHASE_W-1:0] phase_o,
  output cmd_e               cmd_o,
  output logic [ADDR_W-1:0]  addr_o,
  output logic               stg_use_o
);
  logic start_ok;
  assign start_ok = start_i && run_i && !busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o    <= 1'b0;
      phase_o   <= '0;
      cmd_o     <= CMD_MEM;
      addr_o    <= '0;
      stg_use_o <= 1'b0;
    end else if (busy_o) begin
      phase_o <= phase_o + PHASE_W'(1);
      if (phase_o == PH_LAST) busy_o <= 1'b0;
    end else if (start_ok) begin
      busy_o    <= 1'b1;
      phase_o   <= '0;
      cmd_o     <= cmd_e'(cmd_i);
      addr_o    <= addr_i;
      stg_use_o <= (cmd_e'(cmd_i) != CMD_SENSE);
    end else begin
      stg_use_o <= run_i;
    end
  end

  AST_PHASE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && phase_o != PH_LAST |=> busy_o && phase_o == $past(phase_o) + PHASE_W'(1)); // R1
  AST_CYCLE_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && phase_o == PH_LAST |=> !busy_o && phase_o == '0); // R1
  AST_NO_START_STOPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !run_i |=> !busy_o && !stg_use_o); // R9
  AST_USE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> $stable(stg_use_o)); // R5
endmodule

// File: rtl/stg_entry_strobe.sv
module stg_entry_strobe
  import stg_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               busy_i,
  input  logic [PHASE_W-1:0] phase_i,
  input  cmd_e               cmd_i,
  input  logic               stg_use_i,
  output logic               strobe_o
);
  localparam int N_TERMS = 2;
  logic [N_TERMS-1:0] term;
  logic entry_n, entry_n_q;

  // independent case terms, OR-combined into active-low entry sample
  assign term[0] = busy_i && phase_i == PH_FETCH && !stg_use_i;
  assign term[1] = busy_i && phase_i == PH_ENTRY && cmd_i == CMD_READ;
  assign entry_n = ~|term;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) entry_n_q <= 1'b1;
    else         entry_n_q <= entry_n;
  end

  assign strobe_o = entry_n_q && !entry_n;

  AST_STROBE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |=> !strobe_o); // R3
  AST_STROBE_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |-> busy_i && (phase_i == PH_FETCH || phase_i == PH_ENTRY)); // R3
endmodule

// File: rtl/stg_mem.sv
module stg_mem
  import stg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  word_t             wr_word_i,
  output word_t             rd_word_o,
  input  logic              stg_use_i
);
  word_t mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (wr_en_i) begin
      mem_q[addr_i] <= wr_word_i;
    end
  end

  assign rd_word_o = mem_q[addr_i];

  AST_WRITE_NEEDS_USE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> stg_use_i); // R5
endmodule

// File: rtl/stg_sbr.sv
module stg_sbr
  import stg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mem_ld_i,
  input  word_t             mem_word_i,
  input  logic              bus_ld_i,
  input  logic [DATA_W-1:0] bus_i,
  input  logic              chk_i,
  output word_t             sbr_o,
  output logic              perr_o
);
  word_t bus_word;
  assign bus_word.data = bus_i;
  assign bus_word.par  = gen_par(bus_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sbr_o  <= '0;
      perr_o <= 1'b0;
    end else begin
      if (bus_ld_i)      sbr_o <= bus_word;
      else if (mem_ld_i) sbr_o <= mem_word_i;
      if (chk_i && par_bad(sbr_o)) perr_o <= 1'b1;
    end
  end

  AST_PERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    perr_o |=> perr_o); // R8
  AST_LOAD_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_ld_i && mem_ld_i)); // R3
  AST_BUS_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_ld_i |=> sbr_o.data == $past(bus_i) && !par_bad(sbr_o)); // R7
endmodule

// File: rtl/stg_cycle_seq.sv
module stg_cycle_seq
  import stg_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic               start_i,
  input  logic [1:0]         cmd_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  io_bus_i,
  output logic [DATA_W-1:0]  mem_data_o,
  output logic [PHASE_W-1:0] phase_o,
  output logic               cycle_done_o,
  output logic               nsu_o,
  output logic               parity_error_o
);
  logic              busy, stg_use, strobe;
  logic              mem_ld, mem_wr, chk;
  cmd_e              cmd_q;
  logic [ADDR_W-1:0] addr_q;
  word_t             sbr, rd_word;

  stg_phase_ctr u_ctr (
    .clk_i, .rst_ni, .run_i, .start_i, .cmd_i, .addr_i,
    .busy_o(busy), .phase_o, .cmd_o(cmd_q), .addr_o(addr_q), .stg_use_o(stg_use)
  );

  stg_entry_strobe u_strobe (
    .clk_i, .rst_ni, .busy_i(busy), .phase_i(phase_o), .cmd_i(cmd_q),
    .stg_use_i(stg_use), .strobe_o(strobe)
  );

  assign mem_ld = busy && stg_use && phase_o == PH_FETCH;
  assign mem_wr = busy && stg_use && phase_o == PH_LAST;
  assign chk    = busy && phase_o == PH_CHECK;

  stg_mem u_mem (
    .clk_i, .rst_ni, .wr_en_i(mem_wr), .addr_i(addr_q), .wr_word_i(sbr),
    .rd_word_o(rd_word), .stg_use_i(stg_use)
  );

  stg_sbr u_sbr (
    .clk_i, .rst_ni, .mem_ld_i(mem_ld), .mem_word_i(rd_word),
    .bus_ld_i(strobe), .bus_i(io_bus_i), .chk_i(chk),
    .sbr_o(sbr), .perr_o(parity_error_o)
  );

  assign mem_data_o   = sbr.data;
  assign cycle_done_o = busy && phase_o == PH_LAST;
  assign nsu_o        = !stg_use;

  AST_DONE_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cycle_done_o |=> !cycle_done_o && phase_o == '0); // R1
  AST_SENSE_NO_MEM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && nsu_o |-> !mem_ld && !mem_wr); // R5
  AST_REGEN_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && phase_o == PH_LAST && cmd_q != CMD_READ && stg_use |=> $stable(mem_data_o)); // R4
endmodule

// File: tb/stg_cycle_seq_tb_top.sv
module stg_cycle_seq_tb_top;
  logic        clk = 1'b0, rst_n = 1'b0, run = 1'b0, start = 1'b0;
  logic [1:0]  cmd = 2'd0;
  logic [3:0]  addr = 4'd0;
  logic [15:0] bus = 16'h0;
  logic [15:0] mem_data;
  logic [2:0]  phase;
  logic        done, nsu, perr;

  int checks = 0, errors = 0;
  logic [15:0] model [16];
  logic        valid [16];
  logic        exp_perr = 1'b0;

  always #10 clk = ~clk;

  stg_cycle_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .start_i(start), .cmd_i(cmd),
    .addr_i(addr), .io_bus_i(bus), .mem_data_o(mem_data), .phase_o(phase),
    .cycle_done_o(done), .nsu_o(nsu), .parity_error_o(perr)
  );

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 16; i++) begin model[i] = 16'h0; valid[i] = 1'b0; end
    exp_perr = 1'b0;
  endtask

  function automatic logic [15:0] pat(input int a, input int s);
    if (a == 0 && s == 0) return 16'h0000;
    if (a == 15 && s == 0) return 16'hFFFF;
    return 16'((a * 16'h1D37) ^ (s * 16'h5A5A) ^ 16'h8421);
  endfunction

  // b0 drives T0..T2, b1 drives T3..T5, a junk value from T6 on
  task automatic do_cycle(input logic [1:0] c, input logic [3:0] a,
                          input logic [15:0] b0, input logic [15:0] b1);
    logic [15:0] exp_d;
    @(negedge clk); start = 1'b1; cmd = c; addr = a; bus = b0;
    @(negedge clk); start = 1'b0; addr = ~a; cmd = 2'd0;
    for (int k = 0; k < 8; k++) begin
      chk(phase == 3'(k), "R1 phase", 32'(phase), 32'(k));
      chk(done == (k == 7), "R1 done", 32'(done), 32'(k == 7));
      if (k == 1) chk(nsu == (c == 2'd1), "R5 nsu in cycle", 32'(nsu), 32'(c == 2'd1));
      if (k == 3) bus = b1;
      if (k == 6) bus = ~b1 ^ 16'h0F0F;
      @(negedge clk);
    end
    case (c)
      2'd1: exp_d = b0;
      2'd2: begin exp_d = b1; model[a] = b1; valid[a] = 1'b1; end
      default: begin
        exp_d = model[a];
        if (!valid[a]) exp_perr = 1'b1;
      end
    endcase
    chk(phase == 3'd0 && !done, "R1 idle after T7", 32'(phase), 32'd0);
    chk(mem_data == exp_d, (c == 2'd1) ? "R5 sense data" : (c == 2'd2) ? "R6 read data" : "R4 regen data",
        32'(mem_data), 32'(exp_d));
    chk(perr == exp_perr, "R8 parity flag", 32'(perr), 32'(exp_perr));
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin model[i] = 16'h0; valid[i] = 1'b0; end
    #25;
    // R10 reset state
    chk(mem_data == 16'h0, "R10 reset data", 32'(mem_data), 32'h0);
    chk(phase == 3'd0 && !done, "R10 reset phase", 32'(phase), 32'h0);
    chk(!perr, "R8 reset flag", 32'(perr), 32'h0);
    chk(nsu, "R9 nsu stopped", 32'(nsu), 32'h1);
    rst_n = 1'b1;
    // R9 start ignored while stopped
    @(negedge clk); start = 1'b1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(phase == 3'd0 && !done && nsu, "R9 stopped start ignored", 32'(phase), 32'h0);
    end
    start = 1'b0; run = 1'b1;
    @(negedge clk);
    chk(!nsu, "R9 nsu running", 32'(nsu), 32'h0);
    // R6 R7 read cycles over all addresses
    for (int a = 0; a < 16; a++) do_cycle(2'd2, 4'(a), ~pat(a, 0), pat(a, 0));
    // R4 regeneration, twice over
    for (int r = 0; r < 2; r++)
      for (int a = 0; a < 16; a++) do_cycle(2'd0, 4'(a), pat(a, 7), pat(a, 9));
    // R5 sense cycles leave memory untouched
    for (int a = 0; a < 4; a++) begin
      do_cycle(2'd1, 4'(a), pat(a, 3), pat(a, 4));
      @(negedge clk);
      chk(!nsu, "R9 use resumes", 32'(nsu), 32'h0);
      do_cycle(2'd0, 4'(a), 16'h1111, 16'h2222);
    end
    // R2 reserved code acts as memory cycle
    do_cycle(2'd3, 4'd5, 16'hDEAD, 16'hBEEF);
    do_cycle(2'd0, 4'd5, 16'h0, 16'h0);
    // R3 back-to-back bus entries
    do_cycle(2'd2, 4'd6, 16'hAAAA, 16'h5555);
    do_cycle(2'd1, 4'd6, 16'h3C3C, 16'hC3C3);
    // R9 stop again
    run = 1'b0;
    @(negedge clk); @(negedge clk);
    chk(nsu, "R9 nsu after stop", 32'(nsu), 32'h1);
    // R7 R8 unwritten word has bad parity
    do_reset();
    chk(mem_data == 16'h0 && !perr, "R10 reset again", 32'(mem_data), 32'h0);
    run = 1'b1;
    @(negedge clk);
    do_cycle(2'd2, 4'd2, 16'h1234, 16'h4321); // T5 load masks bad word
    do_cycle(2'd0, 4'd9, 16'h0, 16'h0);       // flag set
    do_cycle(2'd2, 4'd9, 16'h0F0F, 16'h7777); // stays set
    do_cycle(2'd0, 4'd9, 16'h0, 16'h0);
    do_reset();
    chk(!perr, "R8 cleared by reset", 32'(perr), 32'h0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule